// File: doc/BRIEF.md
# Lock-Synchronized Stream-to-Memory DMA Channel

This block is one inbound DMA channel. It takes words from a valid/ready stream and writes them into local memory through a plain write port. The target buffers come from a short chain of descriptors. Each descriptor holds a base address, a length, the index of the next descriptor, and two lock indices. One lock guards the empty buffer and belongs to the producer side. The other lock signals a filled buffer and belongs to the consumer side. The channel contains a bank of counting locks that it shares with a processor core through a request/grant port.

For every descriptor, the channel runs the same three steps. First it waits until the producer lock holds at least one token and takes that token. Then it fills the whole buffer. Finally it adds one token to the consumer lock. The core works the other way round. It takes a consumer token before reading a buffer and returns a producer token when it has finished with it. With one descriptor that points at itself, the producer lock starts at 1 and the consumer lock at 0. With two descriptors that point at each other, the producer lock starts at 2, so both buffers can fill before the core frees one. A buffer is normally 256 words of 32 bits. The length field can describe any size from one word up to two to the power LEN_W words.

Top module: `s2mm_lock_channel`

## Requirements
- R1: While reset is high and on the cycle after it falls, all of the following hold: the status phase is idle (code 0), the status descriptor index is 0, stream ready is low, no memory write is issued, and every lock count reads 0.
- R2: When the enable input is high in idle, the next clock edge latches the start-descriptor input as the active descriptor and moves the phase to waiting (code 1).
- R3: While the producer lock of the active descriptor is 0, the channel stays in the waiting phase with ready low and accepts no words. When the count is at least 1, the next edge takes one token and enters the transferring phase (code 2).
- R4: A descriptor's length field holds the word count minus one. Accepted word k of a descriptor (k from 0) is written to base + k, with its data unchanged, on the cycle right after its handshake edge.
- R5: The consumer lock of a descriptor gains one token at the second clock edge after the handshake of that descriptor's last word.
- R6: After a descriptor completes, the channel takes the next index from that descriptor, shows it on the status port, and acquires that descriptor's producer lock. Two descriptors that point at each other, sharing a producer lock that starts at 2, fill both buffers and then stall.
- R7: A core acquire (core_rel = 0) is granted only when the selected count is at least 1, and it takes one token. A core acquire at count 0 is not granted and leaves the count unchanged.
- R8: A core release (core_rel = 1) adds one token and stays at 63 when the count is already 63.
- R9: When the DMA takes or returns a token on the same lock in the same cycle as a core request, the core grant is low in that cycle. The core request is served on a later cycle.
- R10: Dropping enable while the channel is waiting returns it to idle at the next edge. While idle, it takes no producer tokens.
- R11: The status phase uses only codes 0 (idle), 1 (waiting) and 2 (transferring). The cycle that releases the consumer lock reports code 2.
- R12: The lock-preset port writes a count directly and overrides any token change to that lock in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable |
| ch_start_bd | input | BD_W | Descriptor the chain starts from |
| bd_we | input | 1 | Descriptor write strobe |
| bd_idx | input | BD_W | Descriptor slot being written |
| bd_base | input | ADDR_W | Buffer base address |
| bd_len_m1 | input | LEN_W | Buffer length minus one |
| bd_prod_lk | input | LID_W | Producer lock index |
| bd_cons_lk | input | LID_W | Consumer lock index |
| bd_next | input | BD_W | Next descriptor index |
| lk_set | input | 1 | Lock preset strobe |
| lk_set_id | input | LID_W | Lock being preset |
| lk_set_val | input | LOCK_W | Preset count |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Channel accepts a word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| core_req | input | 1 | Core lock request |
| core_rel | input | 1 | 1 = release, 0 = acquire |
| core_lock | input | LID_W | Lock the core addresses (also selects core_lvl) |
| core_gnt | output | 1 | Core request served this cycle |
| core_lvl | output | LOCK_W | Current count of the lock selected by core_lock |
| st_bd | output | BD_W | Active descriptor index |
| st_phase | output | 2 | 0 idle, 1 waiting, 2 transferring |

## Verification
The bench sweeps the buffer length from one word to six words, runs a full 256-word buffer, and runs a ping-pong chain until it stalls on an empty producer lock. An off-by-one in the length field would show up as a missing word or an extra word in the write log. A wrong next-index or address step would put words at the wrong offset. The bench also checks that the channel stalls with ready low when no producer token is left. A design that skipped the acquire would overwrite a buffer the core still holds. The consumer token is checked at the exact edge it should appear, so a release one cycle early or late is caught. The bench also places a core release on the consumer lock in the very cycle the DMA releases it, and checks saturation at 63. A design without arbitration would lose one of the two tokens.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_XFER = 2'd2,
    CS_DONE = 2'd3
  } chan_state_t;

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_WAIT = 2'd1;
  localparam logic [1:0] PH_XFER = 2'd2;

endpackage

// File: rtl/s2mm_bd_table.sv
module s2mm_bd_table #(
  parameter int NUM_BD = 4,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int LID_W  = 3,
  localparam int BD_W  = $clog2(NUM_BD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BD_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LEN_W-1:0]  wr_len_m1,
  input  logic [LID_W-1:0]  wr_prod,
  input  logic [LID_W-1:0]  wr_cons,
  input  logic [BD_W-1:0]   wr_next,
  input  logic [BD_W-1:0]   rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [LEN_W-1:0]  rd_len_m1,
  output logic [LID_W-1:0]  rd_prod,
  output logic [LID_W-1:0]  rd_cons,
  output logic [BD_W-1:0]   rd_next
);

  logic [ADDR_W-1:0] base_q [NUM_BD];
  logic [LEN_W-1:0]  len_q  [NUM_BD];
  logic [LID_W-1:0]  prod_q [NUM_BD];
  logic [LID_W-1:0]  cons_q [NUM_BD];
  logic [BD_W-1:0]   next_q [NUM_BD];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
        prod_q[g] <= '0;
        cons_q[g] <= '0;
        next_q[g] <= '0;
      end else if (wr_en && wr_idx == BD_W'(g)) begin
        base_q[g] <= wr_base;
        len_q[g]  <= wr_len_m1;
        prod_q[g] <= wr_prod;
        cons_q[g] <= wr_cons;
        next_q[g] <= wr_next;
      end
    end
  end

  always_comb begin
    rd_base   = base_q[rd_idx];
    rd_len_m1 = len_q[rd_idx];
    rd_prod   = prod_q[rd_idx];
    rd_cons   = cons_q[rd_idx];
    rd_next   = next_q[rd_idx];
  end

endmodule

// File: rtl/s2mm_lock_bank.sv
module s2mm_lock_bank #(
  parameter int NUM_LOCK = 8,
  parameter int LOCK_W   = 6,
  localparam int LID_W   = $clog2(NUM_LOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic [LID_W-1:0]  set_id,
  input  logic [LOCK_W-1:0] set_val,
  input  logic              dma_acq_req,
  input  logic [LID_W-1:0]  dma_acq_id,
  output logic              dma_acq_gnt,
  input  logic              dma_rel_req,
  input  logic [LID_W-1:0]  dma_rel_id,
  input  logic              core_req,
  input  logic              core_rel,
  input  logic [LID_W-1:0]  core_id,
  output logic              core_gnt,
  output logic [LOCK_W-1:0] core_lvl
);

  localparam logic [LOCK_W-1:0] CNT_MAX = '1;

  logic [LOCK_W-1:0] cnt_q [NUM_LOCK];
  logic [LOCK_W-1:0] cnt_d [NUM_LOCK];
  logic              core_blocked;

  always_comb begin
    dma_acq_gnt  = dma_acq_req && (cnt_q[dma_acq_id] != '0);
    core_blocked = (dma_acq_gnt && dma_acq_id == core_id) ||
                   (dma_rel_req && dma_rel_id == core_id) ||
                   (set_we && set_id == core_id);
    core_gnt     = core_req && !core_blocked &&
                   (core_rel || cnt_q[core_id] != '0);
    core_lvl     = cnt_q[core_id];
  end

  always_comb begin
    for (int i = 0; i < NUM_LOCK; i++) begin
      cnt_d[i] = cnt_q[i];
      if (set_we && set_id == LID_W'(i)) begin
        cnt_d[i] = set_val;
      end else if ((dma_acq_gnt && dma_acq_id == LID_W'(i)) ||
                   (core_gnt && !core_rel && core_id == LID_W'(i))) begin
        cnt_d[i] = cnt_q[i] - 1'b1;
      end else if ((dma_rel_req && dma_rel_id == LID_W'(i)) ||
                   (core_gnt && core_rel && core_id == LID_W'(i))) begin
        if (cnt_q[i] != CNT_MAX) cnt_d[i] = cnt_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LOCK; i++) begin
      if (rst) cnt_q[i] <= '0;
      else     cnt_q[i] <= cnt_d[i];
    end
  end

endmodule

// File: rtl/s2mm_chan_fsm.sv
module s2mm_chan_fsm
  import s2mm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int BD_W   = 2,
  parameter int LID_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_en,
  input  logic [BD_W-1:0]   ch_start_bd,
  input  logic [ADDR_W-1:0] d_base,
  input  logic [LEN_W-1:0]  d_len_m1,
  input  logic [LID_W-1:0]  d_prod,
  input  logic [LID_W-1:0]  d_cons,
  input  logic [BD_W-1:0]   d_next,
  output logic [BD_W-1:0]   cur_bd,
  output logic              acq_req,
  output logic [LID_W-1:0]  acq_id,
  input  logic              acq_gnt,
  output logic              rel_req,
  output logic [LID_W-1:0]  rel_id,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        st_phase
);

  chan_state_t       state_q;
  logic [LEN_W-1:0]  wcnt_q;
  logic              accept;

  always_comb begin
    acq_req = (state_q == CS_WAIT) && ch_en;
    acq_id  = d_prod;
    rel_req = (state_q == CS_DONE);
    rel_id  = d_cons;
    s_ready = (state_q == CS_XFER);
    accept  = s_ready && s_valid;
    unique case (state_q)
      CS_IDLE: st_phase = PH_IDLE;
      CS_WAIT: st_phase = PH_WAIT;
      default: st_phase = PH_XFER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CS_IDLE;
      cur_bd    <= '0;
      wcnt_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= accept;
      if (accept) begin
        mem_addr  <= d_base + ADDR_W'(wcnt_q);
        mem_wdata <= s_data;
      end
      unique case (state_q)
        CS_IDLE: begin
          if (ch_en) begin
            cur_bd  <= ch_start_bd;
            state_q <= CS_WAIT;
          end
        end
        CS_WAIT: begin
          if (!ch_en) begin
            state_q <= CS_IDLE;
          end else if (acq_gnt) begin
            wcnt_q  <= '0;
            state_q <= CS_XFER;
          end
        end
        CS_XFER: begin
          if (accept) begin
            if (wcnt_q == d_len_m1) state_q <= CS_DONE;
            else                    wcnt_q  <= wcnt_q + 1'b1;
          end
        end
        default: begin
          cur_bd  <= d_next;
          state_q <= ch_en ? CS_WAIT : CS_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/s2mm_lock_channel.sv
module s2mm_lock_channel #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int LEN_W    = 8,
  parameter int NUM_BD   = 4,
  parameter int NUM_LOCK = 8,
  parameter int LOCK_W   = 6,
  localparam int BD_W    = $clog2(NUM_BD),
  localparam int LID_W   = $clog2(NUM_LOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_en,
  input  logic [BD_W-1:0]   ch_start_bd,
  input  logic              bd_we,
  input  logic [BD_W-1:0]   bd_idx,
  input  logic [ADDR_W-1:0] bd_base,
  input  logic [LEN_W-1:0]  bd_len_m1,
  input  logic [LID_W-1:0]  bd_prod_lk,
  input  logic [LID_W-1:0]  bd_cons_lk,
  input  logic [BD_W-1:0]   bd_next,
  input  logic              lk_set,
  input  logic [LID_W-1:0]  lk_set_id,
  input  logic [LOCK_W-1:0] lk_set_val,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              core_req,
  input  logic              core_rel,
  input  logic [LID_W-1:0]  core_lock,
  output logic              core_gnt,
  output logic [LOCK_W-1:0] core_lvl,
  output logic [BD_W-1:0]   st_bd,
  output logic [1:0]        st_phase
);

  logic [ADDR_W-1:0] d_base;
  logic [LEN_W-1:0]  d_len_m1;
  logic [LID_W-1:0]  d_prod;
  logic [LID_W-1:0]  d_cons;
  logic [BD_W-1:0]   d_next;
  logic              acq_req;
  logic              acq_gnt;
  logic [LID_W-1:0]  acq_id;
  logic              rel_req;
  logic [LID_W-1:0]  rel_id;

  s2mm_bd_table #(
    .NUM_BD(NUM_BD), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LID_W(LID_W)
  ) bd_i (
    .clk(clk), .rst(rst),
    .wr_en(bd_we), .wr_idx(bd_idx), .wr_base(bd_base),
    .wr_len_m1(bd_len_m1), .wr_prod(bd_prod_lk), .wr_cons(bd_cons_lk),
    .wr_next(bd_next),
    .rd_idx(st_bd), .rd_base(d_base), .rd_len_m1(d_len_m1),
    .rd_prod(d_prod), .rd_cons(d_cons), .rd_next(d_next)
  );

  s2mm_lock_bank #(
    .NUM_LOCK(NUM_LOCK), .LOCK_W(LOCK_W)
  ) lk_i (
    .clk(clk), .rst(rst),
    .set_we(lk_set), .set_id(lk_set_id), .set_val(lk_set_val),
    .dma_acq_req(acq_req), .dma_acq_id(acq_id), .dma_acq_gnt(acq_gnt),
    .dma_rel_req(rel_req), .dma_rel_id(rel_id),
    .core_req(core_req), .core_rel(core_rel), .core_id(core_lock),
    .core_gnt(core_gnt), .core_lvl(core_lvl)
  );

  s2mm_chan_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .BD_W(BD_W), .LID_W(LID_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_start_bd(ch_start_bd),
    .d_base(d_base), .d_len_m1(d_len_m1), .d_prod(d_prod),
    .d_cons(d_cons), .d_next(d_next), .cur_bd(st_bd),
    .acq_req(acq_req), .acq_id(acq_id), .acq_gnt(acq_gnt),
    .rel_req(rel_req), .rel_id(rel_id),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .st_phase(st_phase)
  );

endmodule

// File: rtl/s2mm_lock_channel_chk.sv
module s2mm_lock_channel_chk #(
  parameter int DATA_W = 32,
  parameter int BD_W   = 2,
  parameter int LOCK_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              core_req,
  input logic              core_rel,
  input logic              core_gnt,
  input logic [LOCK_W-1:0] core_lvl,
  input logic [BD_W-1:0]   st_bd,
  input logic [1:0]        st_phase
);

  p_wr_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (mem_we && mem_wdata == $past(s_data)));

  p_no_stray_write_r4: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> !mem_we);

  p_stall_in_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (st_phase == 2'd1) |-> !s_ready);

  p_idle_no_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (st_phase == 2'd0) |-> !s_ready);

  p_core_acq_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_rel && core_lvl == '0) |-> !core_gnt);

  p_phase_legal_r11: assert property (@(posedge clk) disable iff (rst)
    st_phase != 2'd3);

  p_bd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_phase == 2'd2 && $past(st_phase) == 2'd2) |-> $stable(st_bd));

endmodule

bind s2mm_lock_channel s2mm_lock_channel_chk #(
  .DATA_W(DATA_W), .BD_W(BD_W), .LOCK_W(LOCK_W)
) chk_i (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_data(s_data), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .core_req(core_req), .core_rel(core_rel), .core_gnt(core_gnt),
  .core_lvl(core_lvl), .st_bd(st_bd), .st_phase(st_phase)
);

// File: tb/s2mm_lock_channel_tb_top.sv
`timescale 1ns/1ps
module s2mm_lock_channel_tb_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 8;
  localparam int BD_W   = 2;
  localparam int LID_W  = 3;
  localparam int LOCK_W = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              ch_en;
  logic [BD_W-1:0]   ch_start_bd;
  logic              bd_we;
  logic [BD_W-1:0]   bd_idx;
  logic [ADDR_W-1:0] bd_base;
  logic [LEN_W-1:0]  bd_len_m1;
  logic [LID_W-1:0]  bd_prod_lk;
  logic [LID_W-1:0]  bd_cons_lk;
  logic [BD_W-1:0]   bd_next;
  logic              lk_set;
  logic [LID_W-1:0]  lk_set_id;
  logic [LOCK_W-1:0] lk_set_val;
  logic              s_valid;
  logic [DATA_W-1:0] s_data;
  logic              s_ready;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              core_req;
  logic              core_rel;
  logic [LID_W-1:0]  core_lock;
  logic              core_gnt;
  logic [LOCK_W-1:0] core_lvl;
  logic [BD_W-1:0]   st_bd;
  logic [1:0]        st_phase;

  always #10 clk = ~clk;

  s2mm_lock_channel dut_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_start_bd(ch_start_bd),
    .bd_we(bd_we), .bd_idx(bd_idx), .bd_base(bd_base), .bd_len_m1(bd_len_m1),
    .bd_prod_lk(bd_prod_lk), .bd_cons_lk(bd_cons_lk), .bd_next(bd_next),
    .lk_set(lk_set), .lk_set_id(lk_set_id), .lk_set_val(lk_set_val),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .core_req(core_req), .core_rel(core_rel), .core_lock(core_lock),
    .core_gnt(core_gnt), .core_lvl(core_lvl),
    .st_bd(st_bd), .st_phase(st_phase)
  );

  int vecs  = 0;
  int fails = 0;
  int log_n = 0;
  int log_a [512];
  logic [31:0] log_d [512];

  always @(negedge clk) begin
    if (mem_we && log_n < 512) begin
      log_a[log_n] = int'(mem_addr);
      log_d[log_n] = mem_wdata;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ch_en = 1'b0; ch_start_bd = '0; bd_we = 1'b0; bd_idx = '0;
    bd_base = '0; bd_len_m1 = '0; bd_prod_lk = '0; bd_cons_lk = '0;
    bd_next = '0; lk_set = 1'b0; lk_set_id = '0; lk_set_val = '0;
    s_valid = 1'b0; s_data = '0; core_req = 1'b0; core_rel = 1'b0;
    core_lock = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    log_n = 0;
  endtask

  task automatic set_bd(input int idx, input int base, input int lm1,
                        input int pl, input int cl, input int nx);
    bd_we = 1'b1; bd_idx = BD_W'(idx); bd_base = ADDR_W'(base);
    bd_len_m1 = LEN_W'(lm1); bd_prod_lk = LID_W'(pl);
    bd_cons_lk = LID_W'(cl); bd_next = BD_W'(nx);
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic set_lock(input int id, input int val);
    lk_set = 1'b1; lk_set_id = LID_W'(id); lk_set_val = LOCK_W'(val);
    @(negedge clk);
    lk_set = 1'b0;
  endtask

  task automatic rd_lock(input int id, output int v);
    core_lock = LID_W'(id);
    #1;
    v = int'(core_lvl);
  endtask

  task automatic core_do(input bit rel, input int id);
    core_lock = LID_W'(id); core_rel = rel; core_req = 1'b1;
    #1;
    while (!core_gnt) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    core_req = 1'b0;
  endtask

  task automatic send(input int n, input int v0, input int maxwait, output int got);
    int waited;
    got = 0;
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b1;
      s_data  = 32'(v0 + k);
      #1;
      waited = 0;
      while (!s_ready && waited < maxwait) begin
        @(negedge clk);
        #1;
        waited++;
      end
      if (!s_ready) break;
      @(negedge clk);
      got++;
    end
    s_valid = 1'b0;
  endtask

  initial begin
    int v, got, errs, lg0;
    do_reset();
    #1;
    // R1: state straight after reset
    chk("R1 phase", st_phase, 0);
    chk("R1 bd", st_bd, 0);
    chk("R1 ready", s_ready, 0);
    chk("R1 mem_we", mem_we, 0);
    for (int i = 0; i < 8; i++) begin
      rd_lock(i, v);
      chk("R1 lock count", v, 0);
    end

    // R4 sweep of buffer lengths 1..6, R2 start index, R5 consumer token
    for (int L = 0; L < 6; L++) begin
      do_reset();
      set_bd(1, 'h080 + 16 * L, L, 0, 1, 1);
      set_lock(0, 1);
      ch_en = 1'b1; ch_start_bd = 2'd1;
      @(negedge clk);
      #1;
      chk("R2 phase waiting", st_phase, 1);
      chk("R2 start bd", st_bd, 1);
      send(L + 1, 'h1000 * (L + 1), 20, got);
      chk("R4 words accepted", got, L + 1);
      rd_lock(1, v);
      chk("R5 cons before 2nd edge", v, 0);
      @(negedge clk);
      rd_lock(1, v);
      chk("R5 cons after 2nd edge", v, 1);
      errs = 0;
      for (int k = 0; k <= L; k++) begin
        if (log_a[k] != 'h080 + 16 * L + k || log_d[k] != 32'('h1000 * (L + 1) + k))
          errs++;
      end
      chk("R4 writes count", log_n, L + 1);
      chk("R4 address/data errors", errs, 0);
    end

    // R3 stall on empty producer lock, R7 core handshake, R6 re-acquire
    do_reset();
    set_bd(0, 'h100, 3, 0, 1, 0);
    set_lock(0, 1);
    ch_en = 1'b1; ch_start_bd = 2'd0;
    send(4, 'hA0, 20, got);
    chk("R4 single buffer words", got, 4);
    // R11: release cycle reports transferring
    chk("R11 release cycle phase", st_phase, 2);
    repeat (2) @(negedge clk);
    #1;
    chk("R3 waiting phase", st_phase, 1);
    rd_lock(0, v);
    chk("R3 producer token taken", v, 0);
    lg0 = log_n;
    send(1, 'hBAD, 10, got);
    chk("R3 no accept while empty", got, 0);
    chk("R3 no write while empty", log_n, lg0);
    core_do(1'b0, 1);
    rd_lock(1, v);
    chk("R7 core acquire takes token", v, 0);
    core_do(1'b1, 0);
    send(4, 'hC0, 20, got);
    chk("R6 second pass words", got, 4);
    repeat (2) @(negedge clk);
    errs = 0;
    for (int k = 0; k < 4; k++)
      if (log_a[lg0 + k] != 'h100 + k || log_d[lg0 + k] != 32'('hC0 + k)) errs++;
    chk("R6 second pass placement", errs, 0);

    // R6 ping-pong with producer lock at 2
    do_reset();
    set_bd(0, 'h000, 7, 2, 3, 1);
    set_bd(1, 'h040, 7, 2, 3, 0);
    set_lock(2, 2);
    ch_en = 1'b1; ch_start_bd = 2'd0;
    send(24, 'h5000, 20, got);
    chk("R6 two buffers then stall", got, 16);
    #1;
    chk("R6 stalled phase", st_phase, 1);
    chk("R6 back to bd0", st_bd, 0);
    rd_lock(3, v);
    chk("R6 consumer tokens", v, 2);
    rd_lock(2, v);
    chk("R6 producer tokens", v, 0);
    errs = 0;
    for (int k = 0; k < 16; k++) begin
      if (log_a[k] != ((k < 8) ? k : ('h040 + k - 8)) || log_d[k] != 32'('h5000 + k))
        errs++;
    end
    chk("R6 ping-pong placement", errs, 0);
    core_do(1'b0, 3);
    core_do(1'b1, 2);
    send(8, 'h5010, 20, got);
    chk("R6 refill bd0", got, 8);
    repeat (2) @(negedge clk);
    #1;
    chk("R6 moved to bd1", st_bd, 1);
    errs = 0;
    for (int k = 16; k < 24; k++)
      if (log_a[k] != k - 16 || log_d[k] != 32'('h5000 + k)) errs++;
    chk("R6 refill placement", errs, 0);

    // R9 core release collides with DMA release on the same lock
    do_reset();
    set_bd(0, 'h300, 1, 4, 5, 0);
    set_lock(4, 1);
    ch_en = 1'b1;
    send(2, 'h77, 20, got);
    core_lock = 3'd5; core_rel = 1'b1; core_req = 1'b1;
    #1;
    chk("R9 core held off in DMA release cycle", core_gnt, 0);
    @(negedge clk);
    #1;
    chk("R9 core served next cycle", core_gnt, 1);
    @(negedge clk);
    core_req = 1'b0;
    rd_lock(5, v);
    chk("R9 both tokens kept", v, 2);

    // Full 256-word buffer from descriptor 2, then R10 disable
    do_reset();
    set_bd(2, 'h400, 255, 6, 7, 2);
    set_lock(6, 1);
    ch_en = 1'b1; ch_start_bd = 2'd2;
    @(negedge clk);
    #1;
    chk("R2 start from bd2", st_bd, 2);
    send(256, 'h9000, 20, got);
    chk("R4 256 words", got, 256);
    repeat (2) @(negedge clk);
    errs = 0;
    for (int k = 0; k < 256; k++)
      if (log_a[k] != 'h400 + k || log_d[k] != 32'('h9000 + k)) errs++;
    chk("R4 256 placement", errs, 0);
    chk("R4 256 write count", log_n, 256);
    rd_lock(7, v);
    chk("R5 256 consumer token", v, 1);
    ch_en = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 idle after disable", st_phase, 0);
    core_do(1'b1, 6);
    repeat (3) @(negedge clk);
    rd_lock(6, v);
    chk("R10 no acquire while idle", v, 1);

    // R12 preset, R8 saturation, R7 acquire at zero
    do_reset();
    set_lock(5, 62);
    rd_lock(5, v);
    chk("R12 preset value", v, 62);
    core_do(1'b1, 5);
    rd_lock(5, v);
    chk("R8 release to 63", v, 63);
    core_do(1'b1, 5);
    rd_lock(5, v);
    chk("R8 saturate at 63", v, 63);
    core_lock = 3'd4; core_rel = 1'b0; core_req = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk("R7 no grant at zero", core_gnt, 0);
      @(negedge clk);
    end
    core_req = 1'b0;
    rd_lock(4, v);
    chk("R7 count unchanged at zero", v, 0);
    core_do(1'b0, 5);
    rd_lock(5, v);
    chk("R7 acquire decrements", v, 62);
    // R12 preset wins over a core release on the same lock
    lk_set = 1'b1; lk_set_id = 3'd5; lk_set_val = 6'd9;
    core_lock = 3'd5; core_rel = 1'b1; core_req = 1'b1;
    #1;
    chk("R12 core blocked by preset", core_gnt, 0);
    @(negedge clk);
    lk_set = 1'b0; core_req = 1'b0;
    rd_lock(5, v);
    chk("R12 preset overrides", v, 9);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule